// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a synchronous host and an asynchronous fast page mode DRAM with a narrow data path. The host raises a request with a direction, a flat word address and write data. The controller splits the address into a row part and a column part. It time-multiplexes them onto one shared address bus and drives the active-low row strobe, column strobe, write enable and output enable with the ordering and minimum widths the memory needs. It pulses an acknowledge for one clock when the access is finished. On a read, the captured data is presented alongside that acknowledge.

After reset the controller holds every strobe inactive for a power-up pause. It then runs eight refresh cycles in which the column strobe falls before the row strobe, and only after that does it serve the host. From then on an interval timer requests one such refresh per row-count slice of the retention period. A pending refresh wins over a waiting host request at the next point where the bus is free. It never cuts short an access that is in progress. Every timing minimum is a parameter counted in clock cycles.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While reset is held, all four strobes are high, `ack` is 0 and `dram_dq_oe` is 0.
- R2: After reset the strobes stay high for INIT_CYC = INIT_US*CLK_KHZ/1000 cycles. Eight back-to-back column-first refresh cycles follow, and no host request is started before all eight have ended.
- R3: Once the row strobe falls it stays low for at least T_RAS cycles. For a host access it stays low for exactly L = max(T_RAS, T_RCD+T_CAC, T_RAC) cycles.
- R4: Between two row-strobe low periods the row strobe is high for at least P = max(T_RP, T_CP) cycles, and for exactly P cycles when work is already waiting.
- R5: In a host access the bus carries the row (address bits above the low COL_BITS, zero-extended) for cycles 0..T_RCD-1 with the column strobe high. In cycle T_RCD the column strobe falls and the bus carries the column (the low COL_BITS bits, zero-extended).
- R6: In a read, write enable stays high, the data driver is off, and output enable is low exactly while the column strobe is low. `dram_dq_i` is captured at the clock edge that ends cycle L-1.
- R7: In a write, `dram_dq_oe` is 1 and `dram_dq_o` equals the host write data from cycle 0 to the end of the access. Write enable falls together with the column strobe, so the data is on the bus before that edge.
- R8: In a refresh cycle the column strobe is low for one cycle before the row strobe falls. The row strobe then stays low for T_RAS cycles with write enable and output enable high and the data driver off.
- R9: After initialisation a refresh becomes pending every REF_INT = REF_MS*CLK_KHZ/2^ROW_BITS cycles, where REF_MS is 32 for ROW_BITS = 11 and 64 for ROW_BITS = 12.
- R10: When the bus becomes free, a pending refresh is started ahead of a waiting host request. Otherwise the request is started, and otherwise the controller idles.
- R11: `ack` is high for exactly one cycle per access, in cycle L counted from the row-strobe fall, together with the strobes returning high.
- R12: A read returns the data most recently written to the same host address through the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Host request, held until `ack` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_BITS+COL_BITS | Flat word address, row in the upper bits |
| req_wdata | input | DATA_W | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Read data, valid with `ack` on a read |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | max(ROW_BITS,COL_BITS) | Multiplexed row/column address |
| dram_dq_i | input | DATA_W | Data from the memory |
| dram_dq_o | output | DATA_W | Data to the memory |
| dram_dq_oe | output | 1 | Data pad drive enable |

## Verification
The bench holds a request high from the moment reset is released. A controller that skipped or shortened the power-up pause or the eight warm-up refreshes would start that access early and break the cycle-by-cycle comparison. Requests are issued back to back so that refresh deadlines land while an access is in flight and while a request is queued behind it. A controller that preempted the access would release the row strobe too soon, and one that served the host first would show a row address where a column-first refresh belongs. A reference memory on the pins latches the row and column at the strobe edges, so a swapped or truncated address split, or read data sampled one edge early, comes back as wrong data. Addresses with all ones, with row and column values swapped, and addresses never written are included for the same reason.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    typedef enum logic [2:0] {
        ST_POWERUP,
        ST_REF_COL,
        ST_REF_ROW,
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_PRECHG
    } ctl_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fpm_addr_split.sv
module fpm_addr_split #(
    parameter int ROW_BITS = 11,
    parameter int COL_BITS = 10,
    parameter int AB_W     = 11
) (
    input  logic [ROW_BITS+COL_BITS-1:0] host_addr,
    output logic [AB_W-1:0]              row_bus,
    output logic [AB_W-1:0]              col_bus
);
    localparam int HA_W = ROW_BITS + COL_BITS;

    generate
        if (AB_W > ROW_BITS) begin : g_row_pad
            assign row_bus = {{(AB_W-ROW_BITS){1'b0}}, host_addr[HA_W-1:COL_BITS]};
        end else begin : g_row_full
            assign row_bus = host_addr[HA_W-1:COL_BITS];
        end
        if (AB_W > COL_BITS) begin : g_col_pad
            assign col_bus = {{(AB_W-COL_BITS){1'b0}}, host_addr[COL_BITS-1:0]};
        end else begin : g_col_full
            assign col_bus = host_addr[COL_BITS-1:0];
        end
    endgenerate

endmodule

// File: rtl/fpm_refresh_timer.sv
module fpm_refresh_timer #(
    parameter int INTERVAL = 3906
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic take,
    output logic pending
);
    localparam int TW = $clog2(INTERVAL + 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          pend;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        logic tick;
        t_d  = t_q;
        tick = 1'b0;
        if (run) begin
            if (t_q.cnt == TW'(INTERVAL - 1)) begin
                t_d.cnt = '0;
                tick    = 1'b1;
            end else begin
                t_d.cnt = t_q.cnt + TW'(1);
            end
        end
        if (tick)      t_d.pend = 1'b1;
        else if (take) t_d.pend = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) t_q <= '0;
        else     t_q <= t_d;
    end

    assign pending = t_q.pend;

    // R10
    take_valid_chk: assert property (@(posedge clk) disable iff (rst)
        take |-> t_q.pend)
        else $error("refresh taken while none pending");

endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
    parameter int ROW_BITS  = 11,
    parameter int COL_BITS  = 10,
    parameter int DATA_W    = 4,
    parameter int CLK_KHZ   = 250000,
    parameter int INIT_US   = 200,
    parameter int INIT_CBRS = 8,
    parameter int T_RAS     = 12,
    parameter int T_RP      = 10,
    parameter int T_CP      = 3,
    parameter int T_RCD     = 5,
    parameter int T_CAC     = 4,
    parameter int T_RAC     = 15,
    localparam int HA_W     = ROW_BITS + COL_BITS,
    localparam int AB_W     = fpm_pkg::imax(ROW_BITS, COL_BITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_we,
    input  logic [HA_W-1:0]   req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [AB_W-1:0]   dram_addr,
    input  logic [DATA_W-1:0] dram_dq_i,
    output logic [DATA_W-1:0] dram_dq_o,
    output logic              dram_dq_oe
);
    import fpm_pkg::*;

    localparam int REF_MS   = (ROW_BITS >= 12) ? 64 : 32;
    localparam int REF_INT  = REF_MS * CLK_KHZ / (1 << ROW_BITS);
    localparam int INIT_CYC = INIT_US * CLK_KHZ / 1000;
    localparam int L_ACC    = imax(T_RAS, imax(T_RCD + T_CAC, T_RAC));
    localparam int P_PRE    = imax(T_RP, T_CP);
    localparam int CNT_MAX  = imax(imax(INIT_CYC, L_ACC), imax(P_PRE, T_RAS)) + 1;
    localparam int CW       = $clog2(CNT_MAX + 1);
    localparam int IW       = $clog2(INIT_CBRS + 1);

    typedef struct packed {
        ctl_state_e        st;
        logic [CW-1:0]     cnt;
        logic [IW-1:0]     warm_left;
        logic              warm_done;
        logic              job_we;
        logic [AB_W-1:0]   job_row;
        logic [AB_W-1:0]   job_col;
        logic [DATA_W-1:0] job_wd;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
        logic              oe_n;
        logic [AB_W-1:0]   addr;
        logic              dq_oe;
        logic              ack;
        logic [DATA_W-1:0] rdata;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [AB_W-1:0] split_row, split_col;
    logic            ref_pend;
    logic            ref_take;

    fpm_addr_split #(
        .ROW_BITS (ROW_BITS),
        .COL_BITS (COL_BITS),
        .AB_W     (AB_W)
    ) u_split (
        .host_addr (req_addr),
        .row_bus   (split_row),
        .col_bus   (split_col)
    );

    fpm_refresh_timer #(
        .INTERVAL (REF_INT)
    ) u_rtmr (
        .clk     (clk),
        .rst     (rst),
        .run     (c_q.warm_done),
        .take    (ref_take),
        .pending (ref_pend)
    );

    always_comb begin
        logic pick;
        c_d      = c_q;
        c_d.ack  = 1'b0;
        pick     = 1'b0;
        ref_take = 1'b0;

        case (c_q.st)
            ST_POWERUP: begin
                if (c_q.cnt == CW'(INIT_CYC - 1)) begin
                    c_d.st  = ST_REF_COL;
                    c_d.cnt = '0;
                end else begin
                    c_d.cnt = c_q.cnt + CW'(1);
                end
            end
            ST_REF_COL: begin
                c_d.st  = ST_REF_ROW;
                c_d.cnt = '0;
            end
            ST_REF_ROW: begin
                if (c_q.cnt == CW'(T_RAS - 1)) begin
                    c_d.st  = ST_PRECHG;
                    c_d.cnt = '0;
                    if (!c_q.warm_done) begin
                        c_d.warm_left = c_q.warm_left - IW'(1);
                        if (c_q.warm_left == IW'(1)) c_d.warm_done = 1'b1;
                    end
                end else begin
                    c_d.cnt = c_q.cnt + CW'(1);
                end
            end
            ST_ROW: begin
                if (c_q.cnt == CW'(T_RCD - 1)) c_d.st = ST_COL;
                c_d.cnt = c_q.cnt + CW'(1);
            end
            ST_COL: begin
                if (c_q.cnt == CW'(L_ACC - 1)) begin
                    c_d.st  = ST_PRECHG;
                    c_d.cnt = '0;
                    c_d.ack = 1'b1;
                    if (!c_q.job_we) c_d.rdata = dram_dq_i;
                end else begin
                    c_d.cnt = c_q.cnt + CW'(1);
                end
            end
            ST_PRECHG: begin
                if (c_q.cnt == CW'(P_PRE - 1)) pick = 1'b1;
                else                           c_d.cnt = c_q.cnt + CW'(1);
            end
            ST_IDLE:  pick = 1'b1;
            default:  c_d.st = ST_IDLE;
        endcase

        if (pick) begin
            c_d.cnt = '0;
            if (!c_q.warm_done || ref_pend) begin
                c_d.st   = ST_REF_COL;
                ref_take = c_q.warm_done;
            end else if (req) begin
                c_d.st      = ST_ROW;
                c_d.job_we  = req_we;
                c_d.job_row = split_row;
                c_d.job_col = split_col;
                c_d.job_wd  = req_wdata;
            end else begin
                c_d.st = ST_IDLE;
            end
        end

        // strobes and bus follow the next state so that they leave a flop
        c_d.ras_n = !(c_d.st inside {ST_ROW, ST_COL, ST_REF_ROW});
        c_d.cas_n = !(c_d.st inside {ST_COL, ST_REF_COL, ST_REF_ROW});
        c_d.we_n  = !(c_d.st == ST_COL && c_d.job_we);
        c_d.oe_n  = !(c_d.st == ST_COL && !c_d.job_we);
        c_d.dq_oe = (c_d.st inside {ST_ROW, ST_COL}) && c_d.job_we;
        c_d.addr  = (c_d.st == ST_ROW) ? c_d.job_row :
                    (c_d.st == ST_COL) ? c_d.job_col : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q           <= '0;
            c_q.st        <= ST_POWERUP;
            c_q.warm_left <= IW'(INIT_CBRS);
            c_q.ras_n     <= 1'b1;
            c_q.cas_n     <= 1'b1;
            c_q.we_n      <= 1'b1;
            c_q.oe_n      <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign ack        = c_q.ack;
    assign rdata      = c_q.rdata;
    assign dram_ras_n = c_q.ras_n;
    assign dram_cas_n = c_q.cas_n;
    assign dram_we_n  = c_q.we_n;
    assign dram_oe_n  = c_q.oe_n;
    assign dram_addr  = c_q.addr;
    assign dram_dq_o  = c_q.job_wd;
    assign dram_dq_oe = c_q.dq_oe;

    // strobe width trackers used only by the checks below
    logic [CW-1:0] lo_len_q, hi_len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_len_q <= '0;
            hi_len_q <= CW'(P_PRE);
        end else begin
            lo_len_q <= c_q.ras_n ? '0 : lo_len_q + CW'(1);
            hi_len_q <= !c_q.ras_n ? '0 :
                        (hi_len_q == CW'(P_PRE)) ? hi_len_q : hi_len_q + CW'(1);
        end
    end

    // R3
    ras_min_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(c_q.ras_n) |-> (lo_len_q >= CW'(T_RAS)))
        else $error("row strobe released early");

    // R4
    ras_precharge_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(c_q.ras_n) |-> (hi_len_q == CW'(P_PRE)))
        else $error("row strobe precharge too short");

    // R5
    cas_after_row_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(c_q.cas_n) && !c_q.ras_n) |-> (lo_len_q >= CW'(T_RCD)))
        else $error("column strobe too soon after row strobe");

    // R6
    read_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !c_q.oe_n |-> (c_q.we_n && !c_q.dq_oe && !c_q.ras_n && !c_q.cas_n))
        else $error("read cycle with bus conflict");

    // R7
    write_setup_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(c_q.we_n) |-> (c_q.dq_oe && $past(c_q.dq_oe)))
        else $error("write data not set up before write enable");

    // R8
    cbr_order_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(c_q.ras_n) && !c_q.cas_n) |-> ($past(!c_q.cas_n) && c_q.we_n && c_q.oe_n && !c_q.dq_oe))
        else $error("refresh cycle strobe order wrong");

    // R11
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        c_q.ack |=> !c_q.ack)
        else $error("ack longer than one cycle");

endmodule

// File: tb/fpm_dram_ctrl_tb.sv
`timescale 1ns/1ps
module fpm_dram_ctrl_tb;
    localparam int RB = 11, CB = 10, DW = 4, AB = 11, HA = RB + CB;
    localparam int KHZ = 4000;
    localparam int T_RAS = 5, T_RP = 3, T_CP = 2, T_RCD = 2, T_CAC = 2, T_RAC = 7;
    localparam int INIT_CYC = 200 * KHZ / 1000;
    localparam int REF_INT  = 32 * KHZ / 2048;
    localparam int L = 7;   // max(T_RAS, T_RCD+T_CAC, T_RAC)
    localparam int P = 3;   // max(T_RP, T_CP)
    localparam int CMASK = (1 << CB) - 1;

    logic clk = 1'b0, rst = 1'b1;
    logic req = 1'b0, req_we = 1'b0;
    logic [HA-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic ack;
    logic [DW-1:0] rdata;
    logic ras_n, cas_n, we_n, oe_n, dq_oe;
    logic [AB-1:0] dram_addr;
    logic [DW-1:0] dq_i = '0, dq_o;

    always #2 clk = ~clk;

    fpm_dram_ctrl #(
        .ROW_BITS(RB), .COL_BITS(CB), .DATA_W(DW), .CLK_KHZ(KHZ), .INIT_US(200),
        .INIT_CBRS(8), .T_RAS(T_RAS), .T_RP(T_RP), .T_CP(T_CP), .T_RCD(T_RCD),
        .T_CAC(T_CAC), .T_RAC(T_RAC)
    ) u_dut (
        .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .ack(ack), .rdata(rdata), .dram_ras_n(ras_n),
        .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_addr(dram_addr),
        .dram_dq_i(dq_i), .dram_dq_o(dq_o), .dram_dq_oe(dq_oe)
    );

    int n_cmp = 0, n_bad = 0;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    function automatic int dkey(input int row, input int col);
        return row * (1 << AB) + col;
    endfunction
    function automatic logic [3:0] dflt(input int k);
        return 4'((k ^ (k >> 5) ^ 9) & 15);
    endfunction

    // ---------------- behavioural reference of the pin sequence
    // ops: 0 power-up pause, 1 refresh, 2 access, 3 precharge, 4 idle
    int m_op, m_t, m_left, m_done, m_rcnt, m_pend, m_wr, m_row, m_col, m_wd, m_ack;
    int m_refresh, m_cbrs, m_conflicts;

    always @(posedge clk) begin
        int od, opend, pick, take;
        if (rst) begin
            m_op = 0; m_t = 0; m_left = 8; m_done = 0; m_rcnt = 0; m_pend = 0;
            m_wr = 0; m_row = 0; m_col = 0; m_wd = 0; m_ack = 0; m_refresh = 0;
            m_cbrs = 0; m_conflicts = 0;
        end else begin
            od = m_done; opend = m_pend; pick = 0; take = 0;
            m_ack = 0;
            m_t++;
            case (m_op)
                0: if (m_t == INIT_CYC) begin m_op = 1; m_t = 0; m_refresh = 0; m_cbrs++; end
                1: if (m_t == 1 + T_RAS) begin
                       m_op = 3; m_t = 0;
                       if (od == 0) begin m_left--; if (m_left == 0) m_done = 1; end
                   end
                2: if (m_t == L) begin m_op = 3; m_t = 0; m_ack = 1; end
                3: if (m_t == P) pick = 1;
                default: pick = 1;
            endcase
            if (pick != 0) begin
                m_t = 0;
                if (od == 0 || opend != 0) begin
                    if (od != 0 && req) m_conflicts++;
                    m_op = 1; take = od; m_refresh = od; m_cbrs++;
                end else if (req) begin
                    m_op = 2; m_wr = int'(req_we); m_row = int'(req_addr) >> CB;
                    m_col = int'(req_addr) & CMASK; m_wd = int'(req_wdata);
                end else m_op = 4;
            end
            if (od != 0) begin
                if (m_rcnt == REF_INT - 1) begin m_rcnt = 0; m_pend = 1; end
                else begin m_rcnt++; if (take != 0) m_pend = 0; end
            end
        end
    end

    // ---------------- per-cycle comparison of every pin against the reference
    always @(negedge clk) begin
        bit e_ras, e_cas, e_we, e_oe, e_oed;
        string tg, tgd;
        if (!rst) begin
            e_ras = !((m_op == 1 && m_t >= 1) || m_op == 2);
            e_cas = !(m_op == 1 || (m_op == 2 && m_t >= T_RCD));
            e_we  = !(m_op == 2 && m_t >= T_RCD && m_wr != 0);
            e_oe  = !(m_op == 2 && m_t >= T_RCD && m_wr == 0);
            e_oed = (m_op == 2 && m_wr != 0);
            case (m_op)
                0: tg = "R2";
                1: tg = (m_refresh != 0) ? "R10" : "R2";
                2: tg = "R5";
                3: tg = "R4";
                default: tg = "R10";
            endcase
            tgd = (m_op == 2) ? ((m_wr != 0) ? "R7" : "R6") : tg;
            chk(ras_n == e_ras, tg, "ras_n", int'(ras_n), int'(e_ras));
            chk(cas_n == e_cas, tg, "cas_n", int'(cas_n), int'(e_cas));
            chk(we_n == e_we, tgd, "we_n", int'(we_n), int'(e_we));
            chk(oe_n == e_oe, tgd, "oe_n", int'(oe_n), int'(e_oe));
            chk(dq_oe == e_oed, tgd, "dq_oe", int'(dq_oe), int'(e_oed));
            chk(ack == (m_ack != 0), "R11", "ack", int'(ack), m_ack);
            if (m_op == 2)
                chk(int'(dram_addr) == ((m_t < T_RCD) ? m_row : m_col), "R5", "addr",
                    int'(dram_addr), (m_t < T_RCD) ? m_row : m_col);
            if (e_oed)
                chk(int'(dq_o) == m_wd, "R7", "dq_o", int'(dq_o), m_wd);
        end
    end

    // ---------------- pin-level memory and independent timing watch
    logic [3:0] mem [int];
    int row_l = 0, col_l = 0, lo_len = 0, hi_len = 1000, cyc = 0;
    int first_fall = -1, d_cbrs = 0, is_cbr = 0, acks = 0;
    bit p_ras = 1'b1, p_cas = 1'b1;

    always @(posedge clk) if (!rst) cyc++;

    always @(negedge clk) begin
        int k;
        if (rst) begin
            p_ras = 1'b1; p_cas = 1'b1; lo_len = 0; hi_len = 1000;
        end else begin
            if (p_cas && !cas_n && ras_n) d_cbrs++;
            if (p_ras && !ras_n) begin
                if (first_fall < 0) first_fall = cyc;
                chk(hi_len >= P, "R4", "row strobe high width", hi_len, P);
                if (!cas_n) begin
                    is_cbr = 1;
                    chk(!p_cas && we_n && oe_n && !dq_oe, "R8", "refresh strobe order",
                        int'(p_cas), 0);
                end else begin
                    is_cbr = 0;
                    row_l = int'(dram_addr);
                end
            end
            if (!p_ras && ras_n)
                chk(lo_len >= ((is_cbr != 0) ? T_RAS : L), "R3", "row strobe low width",
                    lo_len, (is_cbr != 0) ? T_RAS : L);
            if (p_cas && !cas_n && !ras_n) begin
                col_l = int'(dram_addr);
                chk(lo_len == T_RCD, "R5", "row to column delay", lo_len, T_RCD);
                k = dkey(row_l, col_l);
                if (!we_n) mem[k] = dq_o;
            end
            if (!oe_n && !cas_n && !ras_n) begin
                k = dkey(row_l, col_l);
                dq_i = mem.exists(k) ? mem[k] : dflt(k);
            end else dq_i = '0;
            if (ras_n) begin hi_len++; lo_len = 0; end
            else begin lo_len++; hi_len = 0; end
            p_ras = ras_n; p_cas = cas_n;
        end
    end

    // ---------------- host side
    logic [3:0] sb [int];

    task automatic host_op(input bit wr, input logic [HA-1:0] a, input logic [3:0] d);
        int k;
        logic [3:0] e;
        @(negedge clk);
        req = 1'b1; req_we = wr; req_addr = a; req_wdata = d;
        do @(negedge clk); while (!ack);
        acks++;
        if (acks == 1) begin
            chk(d_cbrs >= 8, "R2", "warm-up refreshes before first access", d_cbrs, 8);
            chk(first_fall >= INIT_CYC, "R2", "power-up pause", first_fall, INIT_CYC);
        end
        if (wr) sb[int'(a)] = d;
        else begin
            k = dkey(int'(a) >> CB, int'(a) & CMASK);
            e = sb.exists(int'(a)) ? sb[int'(a)] : dflt(k);
            chk(rdata == e, (sb.exists(int'(a))) ? "R12" : "R6", "read data", int'(rdata), int'(e));
        end
        @(posedge clk); #1;
        chk(!ack, "R11", "ack width", int'(ack), 0);
        req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(ras_n && cas_n, "R1", "strobes in reset", int'(ras_n & cas_n), 1);
        chk(we_n && oe_n, "R1", "enables in reset", int'(we_n & oe_n), 1);
        chk(!ack && !dq_oe, "R1", "ack/drive in reset", int'(ack | dq_oe), 0);
        rst = 1'b0;
        host_op(1'b1, '0, 4'h3);                 // queued during power-up
        host_op(1'b1, '1, 4'hA);                 // all-ones boundary
        host_op(1'b0, '1, 4'h0);
        host_op(1'b0, '0, 4'h0);
        host_op(1'b0, 21'h12345, 4'h0);          // never written
        host_op(1'b1, HA'((5 << CB) | 7), 4'h1); // row/column swap pair
        host_op(1'b1, HA'((7 << CB) | 5), 4'h2);
        host_op(1'b0, HA'((5 << CB) | 7), 4'h0);
        host_op(1'b0, HA'((7 << CB) | 5), 4'h0);
        for (int i = 0; i < 24; i++) host_op(1'b1, HA'((i * 97531) & ((1 << HA) - 1)), 4'(i));
        for (int i = 0; i < 24; i++) host_op(1'b0, HA'((i * 97531) & ((1 << HA) - 1)), 4'h0);
        host_op(1'b1, '0, 4'hC);                 // overwrite
        host_op(1'b0, '0, 4'h0);
        repeat (200) @(negedge clk);             // refreshes from idle
        host_op(1'b0, '1, 4'h0);
        do @(negedge clk); while (m_op != 4);
        #1;
        chk(d_cbrs == m_cbrs, "R9", "refresh cycle count", d_cbrs, m_cbrs);
        chk(m_cbrs >= 8 + (cyc - INIT_CYC) / REF_INT - 8, "R9", "refresh rate", m_cbrs, 8);
        chk(m_conflicts > 0, "R10", "refresh met a waiting request", m_conflicts, 1);
        report();
    end

    initial begin
        repeat (60000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 60000, 0);
        report();
    end

endmodule